// File: doc/BRIEF.md
# Flash status polling controller

This block sits on the host side of a parallel NOR flash. It decides whether an embedded program or erase that is already running inside the flash has finished, and whether it succeeded. After a single-cycle start request it reads the status word at a target address over a simple request/response port. It keeps reading until the status bits give a verdict, then reports the verdict on a done/pass/fail result that stays put until the next start.

Two detection methods are offered. In data-poll mode (`modeToggle` = 0) bit 7 of each status word is compared against the bit the host expects to find once the operation is over. In toggle mode (`modeToggle` = 1) the controller watches bit 6, which flips on every read while the flash is busy. In both modes bit 5 is the flash's error flag. A set error flag is never taken as final on its own. The controller re-reads to separate an operation that completed just as the flag was raised from one that really failed. An optional cycle watchdog turns a poll that never settles into a failure.

Top module: `flashPollTop`

## Requirements
- R1: While reset is held and right after it is released, `done`, `pass`, `fail` and `rdReq` are all low.
- R2: Each read is a one-cycle `rdReq` pulse carrying the target address latched at start. The first pulse comes in the cycle right after the start is accepted. The next pulse comes in the cycle right after the response (`rdValid`) to the previous one, so at most one read is ever outstanding.
- R3: In data-poll mode, a response whose bit 7 equals the expected bit ends the poll with pass.
- R4: In data-poll mode, a response whose bit 7 differs from the expected bit while bit 5 is 0 leads to another read.
- R5: In data-poll mode, a response whose bit 7 differs while bit 5 is 1 leads to exactly one more read. That read's bit 7 decides: equal to the expected bit gives pass, different gives fail.
- R6: In toggle mode, the first read only records bit 6. If any later read returns the same bit 6 as the read before it, the result is pass.
- R7: In toggle mode, a changed bit 6 with bit 5 at 0 leads to another read, which is compared against the most recent value.
- R8: In toggle mode, a changed bit 6 with bit 5 at 1 leads to two more reads. If bit 6 differs between them the result is fail, otherwise pass.
- R9: `done` rises, with exactly one of `pass`/`fail`, in the cycle after the deciding response. All three hold until the next accepted start. A start raised while a poll is in progress is ignored.
- R10: With the watchdog enabled, a poll that has not reached a verdict WDOG_LIMIT cycles after the start edge ends with `done` and `fail` at that edge. A verdict that falls on the same edge takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a poll (ignored while one is running) |
| modeToggle | input | 1 | 0 = data-poll method, 1 = toggle method |
| expectBit | input | 1 | Value bit 7 takes once the operation is complete |
| targetAddr | input | AW | Address to read status from |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | AW | Read address |
| rdValid | input | 1 | One-cycle read response strobe |
| rdData | input | DW | Status word returned by the flash |
| done | output | 1 | Verdict available |
| pass | output | 1 | Operation completed correctly |
| fail | output | 1 | Operation failed or watchdog expired |

## Verification
The assertions assume the flash side behaves: `rdValid` pulses for a single cycle, only for a request that is still outstanding, and at least one cycle after that request. The bench responder honours this by answering each request after a fixed latency of one to three cycles, chosen per case. Every response comes from a scripted queue, followed by a fill value, so each status pattern reaches the controller at a known cycle. Start pulses are one cycle wide. The one start raised mid-poll lands well before the predicted verdict edge.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int ERR_BIT    = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } poll_state_e;

  typedef enum logic [2:0] {
    PH_DP_MAIN,
    PH_DP_CONFIRM,
    PH_TG_FIRST,
    PH_TG_POLL,
    PH_TG_CONF1,
    PH_TG_CONF2
  } poll_phase_e;

  typedef struct packed {
    logic loadJob;
    logic capturePrev;
    logic setPass;
    logic setFail;
    logic wdogRun;
  } poll_strobe_t;

endpackage

// File: rtl/flashPollDatapath.sv
module flashPollDatapath
  import flash_poll_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 8,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  poll_strobe_t  strobe,
  input  logic [AW-1:0] targetAddr,
  input  logic          expectBit,
  input  logic [DW-1:0] rdData,
  output logic [AW-1:0] rdAddr,
  output logic          pollMatch,
  output logic          toggleSeen,
  output logic          errSeen,
  output logic          wdogExpired,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  logic [AW-1:0] addrReg;
  logic          expectReg;
  logic          prevToggle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg    <= '0;
      expectReg  <= 1'b0;
      prevToggle <= 1'b0;
    end else begin
      if (strobe.loadJob) begin
        addrReg   <= targetAddr;
        expectReg <= expectBit;
      end
      if (strobe.capturePrev) prevToggle <= rdData[TOGGLE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (strobe.loadJob) begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else if (strobe.setPass) begin
      done <= 1'b1;
      pass <= 1'b1;
    end else if (strobe.setFail) begin
      done <= 1'b1;
      fail <= 1'b1;
    end
  end

  assign rdAddr     = addrReg;
  assign pollMatch  = (rdData[POLL_BIT] == expectReg);
  assign toggleSeen = (rdData[TOGGLE_BIT] != prevToggle);
  assign errSeen    = rdData[ERR_BIT];

  generate
    if (WDOG_EN) begin : g_wdog
      localparam int CW = $clog2(WDOG_LIMIT + 1);
      localparam logic [CW-1:0] LAST = CW'(WDOG_LIMIT - 1);
      logic [CW-1:0] cycleCnt;

      always_ff @(posedge clk) begin
        if (!rstN)                cycleCnt <= '0;
        else if (strobe.loadJob)  cycleCnt <= '0;
        else if (strobe.wdogRun)  cycleCnt <= cycleCnt + 1'b1;
      end

      assign wdogExpired = (cycleCnt == LAST);
    end else begin : g_nowdog
      assign wdogExpired = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/flashPollCtrl.sv
module flashPollCtrl
  import flash_poll_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         modeToggle,
  input  logic         rdValid,
  input  logic         pollMatch,
  input  logic         toggleSeen,
  input  logic         errSeen,
  input  logic         wdogExpired,
  output poll_strobe_t strobe,
  output logic         rdReq
);

  poll_state_e state, nextState;
  poll_phase_e phase, nextPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_DP_MAIN;
    end else begin
      state <= nextState;
      phase <= nextPhase;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextPhase = phase;

    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.loadJob = 1'b1;
          nextPhase      = modeToggle ? PH_TG_FIRST : PH_DP_MAIN;
          nextState      = ST_ISSUE;
        end
      end

      ST_ISSUE: begin
        strobe.wdogRun = 1'b1;
        nextState      = ST_WAIT;
      end

      ST_WAIT: begin
        strobe.wdogRun = 1'b1;
        if (rdValid) begin
          nextState = ST_ISSUE;
          unique case (phase)
            PH_DP_MAIN: begin
              if (pollMatch)    strobe.setPass = 1'b1;
              else if (errSeen) nextPhase = PH_DP_CONFIRM;
            end
            PH_DP_CONFIRM: begin
              if (pollMatch) strobe.setPass = 1'b1;
              else           strobe.setFail = 1'b1;
            end
            PH_TG_FIRST: begin
              strobe.capturePrev = 1'b1;
              nextPhase          = PH_TG_POLL;
            end
            PH_TG_POLL: begin
              if (!toggleSeen) begin
                strobe.setPass = 1'b1;
              end else if (!errSeen) begin
                strobe.capturePrev = 1'b1;
              end else begin
                nextPhase = PH_TG_CONF1;
              end
            end
            PH_TG_CONF1: begin
              strobe.capturePrev = 1'b1;
              nextPhase          = PH_TG_CONF2;
            end
            PH_TG_CONF2: begin
              if (toggleSeen) strobe.setFail = 1'b1;
              else            strobe.setPass = 1'b1;
            end
            default: nextPhase = PH_DP_MAIN;
          endcase
          if (strobe.setPass || strobe.setFail) nextState = ST_IDLE;
        end
      end

      default: nextState = ST_IDLE;
    endcase

    if (state != ST_IDLE && !strobe.setPass && !strobe.setFail && wdogExpired) begin
      strobe.setFail = 1'b1;
      nextState      = ST_IDLE;
    end
  end

  assign rdReq = (state == ST_ISSUE);

endmodule

// File: rtl/flashPollTop.sv
module flashPollTop
  import flash_poll_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 8,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          modeToggle,
  input  logic          expectBit,
  input  logic [AW-1:0] targetAddr,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  input  logic          rdValid,
  input  logic [DW-1:0] rdData,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  poll_strobe_t strobe;
  logic pollMatch, toggleSeen, errSeen, wdogExpired;

  flashPollCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .modeToggle  (modeToggle),
    .rdValid     (rdValid),
    .pollMatch   (pollMatch),
    .toggleSeen  (toggleSeen),
    .errSeen     (errSeen),
    .wdogExpired (wdogExpired),
    .strobe      (strobe),
    .rdReq       (rdReq)
  );

  flashPollDatapath #(
    .AW         (AW),
    .DW         (DW),
    .WDOG_EN    (WDOG_EN),
    .WDOG_LIMIT (WDOG_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .targetAddr  (targetAddr),
    .expectBit   (expectBit),
    .rdData      (rdData),
    .rdAddr      (rdAddr),
    .pollMatch   (pollMatch),
    .toggleSeen  (toggleSeen),
    .errSeen     (errSeen),
    .wdogExpired (wdogExpired),
    .done        (done),
    .pass        (pass),
    .fail        (fail)
  );

endmodule

// File: rtl/flashPollChecker.sv
module flashPollChecker #(
  parameter int AW         = 18,
  parameter int DW         = 8,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_LIMIT = 4096
) (
  input logic          clk,
  input logic          rstN,
  input logic          startPulse,
  input logic          modeToggle,
  input logic          expectBit,
  input logic          rdReq,
  input logic [AW-1:0] rdAddr,
  input logic          rdValid,
  input logic [DW-1:0] rdData,
  input logic          done,
  input logic          pass,
  input logic          fail
);

  logic busyC, outstanding, modeC, expC;
  int   busyCycles;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyC      <= 1'b0;
      busyCycles <= 0;
      modeC      <= 1'b0;
      expC       <= 1'b0;
    end else if (startPulse && (!busyC || done)) begin
      busyC      <= 1'b1;
      busyCycles <= 0;
      modeC      <= modeToggle;
      expC       <= expectBit;
    end else if (busyC && done) begin
      busyC <= 1'b0;
    end else if (busyC) begin
      busyCycles <= busyCycles + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                outstanding <= 1'b0;
    else if (rdReq)           outstanding <= 1'b1;
    else if (rdValid || done) outstanding <= 1'b0;
  end

  // R2: a request lasts one cycle
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R2: never a second request while one is outstanding
  p_single_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !outstanding);

  // R2: address only moves on a start
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> $stable(rdAddr));

  // R3: data-poll match gives pass on the next cycle
  p_dp_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyC && !done && outstanding && rdValid && !modeC && rdData[7] == expC)
      |=> (done && pass));

  // R9: result encoding
  p_result_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pass, fail}) && (done == (pass || fail)));

  // R9: result held until a start
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> (done && $stable(pass) && $stable(fail)));

  // R9: no reads once the verdict is out
  p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rdReq);

  generate
    if (WDOG_EN) begin : g_wd_chk
      // R10: verdict within the watchdog window
      p_wdog_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
        busyC |-> (busyCycles <= WDOG_LIMIT));
    end
  endgenerate

endmodule

bind flashPollTop flashPollChecker #(
  .AW(AW), .DW(DW), .WDOG_EN(WDOG_EN), .WDOG_LIMIT(WDOG_LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeToggle(modeToggle),
  .expectBit(expectBit), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
  .rdData(rdData), .done(done), .pass(pass), .fail(fail)
);

// File: tb/flashPollTop_test.sv
`timescale 1ns/1ps
module flashPollTop_test;

  localparam int AW  = 18;
  localparam int DW  = 8;
  localparam int LIM = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          modeToggle = 1'b0;
  logic          expectBit = 1'b0;
  logic [AW-1:0] targetAddr = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          done, pass, fail;

  flashPollTop #(.AW(AW), .DW(DW), .WDOG_EN(1'b1), .WDOG_LIMIT(LIM)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .modeToggle(modeToggle),
    .expectBit(expectBit), .targetAddr(targetAddr), .rdReq(rdReq),
    .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .done(done), .pass(pass), .fail(fail)
  );

  int checks = 0;
  int failures = 0;

  byte unsigned  respQ[$];
  byte unsigned  fillByte = 8'h00;
  int            lat = 1;
  int            waitCnt = 0;
  logic [AW-1:0] expAddr = '0;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // flash responder: answers each request after lat cycles
  always @(posedge clk) begin
    rdValid <= 1'b0;
    if (rdReq) begin
      checks++;
      if (rdAddr !== expAddr) begin
        failures++;
        $display("FAIL R2 address actual=%h expected=%h", rdAddr, expAddr);
      end
      waitCnt = lat;
    end
    if (waitCnt > 0) begin
      waitCnt--;
      if (waitCnt == 0) begin
        rdValid <= 1'b1;
        rdData  <= (respQ.size() > 0) ? respQ.pop_front() : fillByte;
      end
    end
  end

  function automatic byte unsigned pick(const ref byte unsigned q[$],
                                        input byte unsigned f, ref int i);
    byte unsigned b;
    b = (i < q.size()) ? q[i] : f;
    i++;
    return b;
  endfunction

  // outcome of the flowchart: reads used (-1 = never settles) and verdict
  function automatic void evalModel(input bit mode, input bit expB,
                                    const ref byte unsigned q[$],
                                    input byte unsigned f,
                                    output int n, output bit ok);
    int i = 0;
    byte unsigned b;
    bit prev;
    n = -1;
    ok = 1'b0;
    if (!mode) begin
      while (i < 200) begin
        b = pick(q, f, i);
        if (b[7] == expB) begin ok = 1'b1; n = i; return; end
        if (b[5]) begin
          b = pick(q, f, i);
          ok = (b[7] == expB);
          n = i;
          return;
        end
      end
    end else begin
      b = pick(q, f, i);
      prev = b[6];
      while (i < 200) begin
        b = pick(q, f, i);
        if (b[6] == prev) begin ok = 1'b1; n = i; return; end
        if (!b[5]) begin
          prev = b[6];
        end else begin
          b = pick(q, f, i);
          prev = b[6];
          b = pick(q, f, i);
          ok = (b[6] == prev);
          n = i;
          return;
        end
      end
    end
  endfunction

  task automatic runCase(input string tag, input bit mode, input bit expB,
                         input int latency, input byte unsigned q[$],
                         input byte unsigned fill, input logic [AW-1:0] addr,
                         input int midStartAt);
    int n, d, per;
    bit ok, expOk;
    evalModel(mode, expB, q, fill, n, ok);
    per = 1 + latency;
    if (n >= 0 && n * per <= LIM) begin
      d = n * per;
      expOk = ok;
    end else begin
      d = LIM;
      expOk = 1'b0;
    end
    respQ    = q;
    fillByte = fill;
    lat      = latency;
    expAddr  = addr;
    @(negedge clk);
    startPulse = 1'b1;
    modeToggle = mode;
    expectBit  = expB;
    targetAddr = addr;
    @(negedge clk);
    startPulse = 1'b0;
    targetAddr = ~addr;      // R2: address must stay latched
    for (int k = 0; k <= d + 4; k++) begin
      chk({tag, " R2 rdReq"}, rdReq, (k < d) && (k % per == 0));
      chk({tag, " R9 done"}, done, k >= d);
      if (k >= d) begin
        chk({tag, " pass"}, pass, expOk);
        chk({tag, " fail"}, fail, !expOk);
      end
      if (k == midStartAt) begin
        startPulse = 1'b1;        // R9: ignored while busy
        modeToggle = ~mode;
        expectBit  = ~expB;
      end else begin
        startPulse = 1'b0;
      end
      @(negedge clk);
    end
    startPulse = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 1'b0);
    chk("R1 pass in reset", pass, 1'b0);
    chk("R1 fail in reset", fail, 1'b0);
    chk("R1 rdReq in reset", rdReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", done, 1'b0);
    chk("R1 rdReq after reset", rdReq, 1'b0);

    runCase("R3 match first",      1'b0, 1'b1, 1, '{8'h80}, 8'h00, 18'h01234, -1);
    runCase("R4 reread",           1'b0, 1'b1, 2, '{8'h00, 8'h00, 8'h80}, 8'h00, 18'h3ffff, -1);
    runCase("R5 late completion",  1'b0, 1'b1, 3, '{8'h20, 8'h80}, 8'h00, 18'h2aaaa, -1);
    runCase("R5 true failure",     1'b0, 1'b1, 1, '{8'h20, 8'h20}, 8'h00, 18'h15555, -1);
    runCase("R3 expect zero",      1'b0, 1'b0, 2, '{8'h80, 8'h00}, 8'h00, 18'h00f0f, -1);
    runCase("R6 no toggle",        1'b1, 1'b0, 1, '{8'h40, 8'h40}, 8'h00, 18'h0aaaa, -1);
    runCase("R7 toggle then stop", 1'b1, 1'b0, 2, '{8'h00, 8'h40, 8'h00, 8'h00}, 8'h00, 18'h10001, -1);
    runCase("R8 still toggling",   1'b1, 1'b0, 1, '{8'h00, 8'h60, 8'h00, 8'h40}, 8'h00, 18'h20002, -1);
    runCase("R8 settled",          1'b1, 1'b0, 3, '{8'h00, 8'h60, 8'h40, 8'h40}, 8'h00, 18'h30003, -1);
    runCase("R10 dp never done",   1'b0, 1'b1, 2, '{8'h00}, 8'h00, 18'h00001, -1);
    runCase("R10 toggle forever",  1'b1, 1'b0, 1, '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                                                   8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                                                   8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                                                   8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                                                   8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40,
                                                   8'h00, 8'h40}, 8'h00, 18'h00002, -1);
    runCase("R9 start while busy", 1'b1, 1'b0, 3, '{8'h00, 8'h40, 8'h00, 8'h00}, 8'h00, 18'h12345, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule